// File: doc/BRIEF.md
# Completion Error Masking Bridge

This block connects a CPU-facing AXI4-Lite slave port to a simple request/completion port of a PCIe core. It forwards memory and configuration reads and writes one at a time. It turns failed completions, meaning Unsupported Request, Completer Abort or no answer at all, into harmless bus responses, so that a missing or broken downstream device never raises a fatal slave error on the CPU. A mode input selects between this masking behaviour and plain error reporting.

Configuration accesses are checked before they are sent. Only the root port's own function and device 0 on the secondary bus can exist. An access to any other bus, device or function, or to the secondary bus while the link is down, is answered by the bridge itself and never reaches the core. Every masked or filtered event sets a sticky flag and records its address, which lets software find out afterwards what was hidden from it.

Top module: `cpl_err_mask_bridge`

## Requirements
- R1: A memory access (address bit 31 = 0) or a valid configuration access is presented once on the core port, with `c_req_cfg` equal to address bit 31 and with the address, write flag, write data and strobes of the AXI request. A completion with status 3'b000 (success) answers with OKAY (2'b00) and, for a read, the completion data.
- R2: With `mask_en` = 1, a completion with status 3'b001 (Unsupported Request) or 3'b100 (Completer Abort) answers with OKAY and read data 0xFFFFFFFF. The same holds for configuration and memory accesses, and for reads and writes.
- R3: With `mask_en` = 0, those two statuses answer with SLVERR (2'b10) on the read and the write response channel.
- R4: A configuration access uses bus = addr[27:20], device = addr[19:15] and function = addr[14:12]. It is valid only if it is on the primary bus to device `RP_DEV` function 0, or on the secondary bus to device 0. Any other access is never forwarded and is answered with OKAY and data 0xFFFFFFFF, whatever the value of `mask_en`.
- R5: While `link_up` = 0, a secondary-bus access is handled as filtered. An access to the root port's own function is still forwarded.
- R6: A filtered access gets its response valid in the cycle after the accepting edge.
- R7: If no completion arrives, the response appears exactly `TMO_CYC` cycles after the accepting edge. It is handled like an Unsupported Request: OKAY with all-ones data when masked, SLVERR when not.
- R8: `err_flags` bit 0 = masked Unsupported Request, bit 1 = masked Completer Abort, bit 2 = masked timeout, bit 3 = filtered. Each bit stays set until a 1 is applied on the same bit of `err_clr`. `err_addr` holds the address of the latest such event.
- R9: Only one access is in flight. All three ready outputs are low from acceptance until the response handshake. A write needs `s_awvalid` and `s_wvalid` together, and it wins over a read offered in the same cycle.
- R10: An error that is reported as SLVERR sets no flag.
- R11: After reset, no valid is asserted and `err_flags` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mask_en | input | 1 | 1: hide failed completions, 0: report SLVERR |
| link_up | input | 1 | Downstream link state |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_awaddr | input | AW | Write address |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_wdata | input | DW | Write data |
| s_wstrb | input | DW/8 | Write byte strobes |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_bresp | output | 2 | Write response code |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_araddr | input | AW | Read address |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| s_rdata | output | DW | Read data |
| s_rresp | output | 2 | Read response code |
| c_req_valid | output | 1 | Request to core valid |
| c_req_ready | input | 1 | Core takes the request |
| c_req_write | output | 1 | Request is a write |
| c_req_cfg | output | 1 | Request is a configuration access |
| c_req_addr | output | AW | Request address |
| c_req_wdata | output | DW | Request write data |
| c_req_wstrb | output | DW/8 | Request byte strobes |
| c_cpl_valid | input | 1 | Completion valid |
| c_cpl_status | input | 3 | Completion status |
| c_cpl_data | input | DW | Completion read data |
| err_flags | output | 4 | Sticky event flags |
| err_addr | output | AW | Address of the latest logged event |
| err_clr | input | 4 | Write-one-to-clear pulses for the flags |

## Verification
The bench drives configuration accesses at the edges of the filter: function 1 of the root port, a non-zero device on the secondary bus, an unknown bus, and the secondary bus with the link down. A design that checked only the bus number would forward these accesses, and the counter of core requests in the bench would show it. Timeouts are timed to the exact cycle, once with masking on and once with it off. An off-by-one counter, or a timeout that ignores the mode, gives a wrong cycle count or a wrong response code. The flag tests clear one bit while others stay set, and they run unmasked errors to confirm that those leave the flags alone. Combinational ready checks catch a write accepted without its data, a read that beats a write, and a port that accepts a new access while one is in flight.

// File: rtl/cplmask_pkg.sv
package cplmask_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_RESP} br_state_e;

  localparam logic [1:0] RESP_OKAY   = 2'b00;
  localparam logic [1:0] RESP_SLVERR = 2'b10;

  localparam logic [2:0] CPL_SC = 3'b000;
  localparam logic [2:0] CPL_UR = 3'b001;
  localparam logic [2:0] CPL_CA = 3'b100;

  localparam int FLG_UR   = 0;
  localparam int FLG_CA   = 1;
  localparam int FLG_TMO  = 2;
  localparam int FLG_FILT = 3;
  localparam int NFLG     = 4;

  localparam int BUS_LSB = 20;
  localparam int DEV_LSB = 15;
  localparam int FN_LSB  = 12;
endpackage

// File: rtl/cplmask_cfg_filter.sv
module cplmask_cfg_filter #(
  parameter int AW = 32,
  parameter logic [7:0] PRI_BUS = 8'd0,
  parameter logic [7:0] SEC_BUS = 8'd1,
  parameter logic [4:0] RP_DEV  = 5'd0
) (
  input  logic [AW-1:0] addr,
  input  logic          link_up,
  output logic          is_cfg,
  output logic          drop
);
  import cplmask_pkg::*;

  logic [7:0] bus;
  logic [4:0] dev;
  logic [2:0] fn;
  logic       own_fn, sec_dev0;

  assign is_cfg   = addr[AW-1];
  assign bus      = addr[BUS_LSB +: 8];
  assign dev      = addr[DEV_LSB +: 5];
  assign fn       = addr[FN_LSB +: 3];
  assign own_fn   = (bus == PRI_BUS) && (dev == RP_DEV) && (fn == 3'd0);
  assign sec_dev0 = (bus == SEC_BUS) && (dev == 5'd0);
  assign drop     = is_cfg && !(own_fn || (sec_dev0 && link_up));
endmodule

// File: rtl/cplmask_timer.sv
module cplmask_timer #(
  parameter int TMO_CYC = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic run,
  output logic expired
);
  localparam int TW = $clog2(TMO_CYC + 1);
  localparam logic [TW-1:0] LAST = TW'(TMO_CYC - 1);

  logic [TW-1:0] cnt;

  assign expired = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || start) cnt <= '0;
    else if (run)     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/cplmask_logger.sv
module cplmask_logger #(
  parameter int AW = 32,
  parameter int NF = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NF-1:0] ev,
  input  logic [AW-1:0] ev_addr,
  input  logic [NF-1:0] clr,
  output logic [NF-1:0] flags,
  output logic [AW-1:0] last_addr
);
  for (genvar i = 0; i < NF; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)        flags[i] <= 1'b0;
      else if (ev[i]) flags[i] <= 1'b1;
      else if (clr[i]) flags[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)      last_addr <= '0;
    else if (|ev) last_addr <= ev_addr;
  end
endmodule

// File: rtl/cpl_err_mask_bridge.sv
module cpl_err_mask_bridge #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int TMO_CYC = 1024,
  parameter logic [7:0] PRI_BUS = 8'd0,
  parameter logic [7:0] SEC_BUS = 8'd1,
  parameter logic [4:0] RP_DEV  = 5'd0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            mask_en,
  input  logic            link_up,
  input  logic            s_awvalid,
  output logic            s_awready,
  input  logic [AW-1:0]   s_awaddr,
  input  logic            s_wvalid,
  output logic            s_wready,
  input  logic [DW-1:0]   s_wdata,
  input  logic [DW/8-1:0] s_wstrb,
  output logic            s_bvalid,
  input  logic            s_bready,
  output logic [1:0]      s_bresp,
  input  logic            s_arvalid,
  output logic            s_arready,
  input  logic [AW-1:0]   s_araddr,
  output logic            s_rvalid,
  input  logic            s_rready,
  output logic [DW-1:0]   s_rdata,
  output logic [1:0]      s_rresp,
  output logic            c_req_valid,
  input  logic            c_req_ready,
  output logic            c_req_write,
  output logic            c_req_cfg,
  output logic [AW-1:0]   c_req_addr,
  output logic [DW-1:0]   c_req_wdata,
  output logic [DW/8-1:0] c_req_wstrb,
  input  logic            c_cpl_valid,
  input  logic [2:0]      c_cpl_status,
  input  logic [DW-1:0]   c_cpl_data,
  output logic [3:0]      err_flags,
  output logic [AW-1:0]   err_addr,
  input  logic [3:0]      err_clr
);
  import cplmask_pkg::*;

  localparam logic [DW-1:0] ALL_ONES = '1;

  br_state_e st;
  logic wr_go, rd_go, acc, acc_cfg, acc_drop, expired, in_flight, cpl_hit;
  logic [AW-1:0] acc_addr;
  logic fin, fin_err;
  logic [1:0] fin_resp;
  logic [DW-1:0] fin_data;
  logic [NFLG-1:0] ev;

  // Acceptance: only in idle, write needs both channels, write wins
  assign wr_go     = (st == ST_IDLE) && s_awvalid && s_wvalid;
  assign rd_go     = (st == ST_IDLE) && s_arvalid && !(s_awvalid && s_wvalid);
  assign acc       = wr_go || rd_go;
  assign s_awready = wr_go;
  assign s_wready  = wr_go;
  assign s_arready = rd_go;
  assign acc_addr  = wr_go ? s_awaddr : s_araddr;

  cplmask_cfg_filter #(.AW(AW), .PRI_BUS(PRI_BUS), .SEC_BUS(SEC_BUS), .RP_DEV(RP_DEV)) u_filter (
    .addr(acc_addr), .link_up(link_up), .is_cfg(acc_cfg), .drop(acc_drop)
  );

  assign in_flight = (st == ST_ISSUE) || (st == ST_WAIT);

  cplmask_timer #(.TMO_CYC(TMO_CYC)) u_timer (
    .clk(clk), .rst(rst), .start(acc), .run(in_flight), .expired(expired)
  );

  // Outcome of a forwarded access; a completion beats the timeout
  assign cpl_hit = (st == ST_WAIT) && c_cpl_valid;
  always_comb begin
    fin      = cpl_hit || expired;
    fin_err  = cpl_hit ? (c_cpl_status != CPL_SC) : expired;
    fin_resp = (fin_err && !mask_en) ? RESP_SLVERR : RESP_OKAY;
    fin_data = fin_err ? ALL_ONES : c_cpl_data;
  end

  always_comb begin
    ev           = '0;
    ev[FLG_FILT] = acc && acc_drop;
    ev[FLG_TMO]  = expired && !cpl_hit && mask_en;
    ev[FLG_CA]   = cpl_hit && mask_en && (c_cpl_status == CPL_CA);
    ev[FLG_UR]   = cpl_hit && mask_en && fin_err && (c_cpl_status != CPL_CA);
  end

  cplmask_logger #(.AW(AW), .NF(NFLG)) u_log (
    .clk(clk), .rst(rst), .ev(ev), .ev_addr(acc ? acc_addr : c_req_addr),
    .clr(err_clr), .flags(err_flags), .last_addr(err_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      c_req_valid <= 1'b0;
      c_req_write <= 1'b0;
      c_req_cfg   <= 1'b0;
      c_req_addr  <= '0;
      c_req_wdata <= '0;
      c_req_wstrb <= '0;
      s_bvalid    <= 1'b0;
      s_bresp     <= RESP_OKAY;
      s_rvalid    <= 1'b0;
      s_rresp     <= RESP_OKAY;
      s_rdata     <= '0;
    end else begin
      case (st)
        ST_IDLE: if (acc) begin
          c_req_write <= wr_go;
          c_req_cfg   <= acc_cfg;
          c_req_addr  <= acc_addr;
          c_req_wdata <= s_wdata;
          c_req_wstrb <= wr_go ? s_wstrb : '0;
          if (acc_drop) begin
            st       <= ST_RESP;
            s_bvalid <= wr_go;
            s_rvalid <= !wr_go;
            s_bresp  <= RESP_OKAY;
            s_rresp  <= RESP_OKAY;
            s_rdata  <= ALL_ONES;
          end else begin
            st          <= ST_ISSUE;
            c_req_valid <= 1'b1;
          end
        end
        ST_ISSUE, ST_WAIT: begin
          if (st == ST_ISSUE && c_req_ready) begin
            c_req_valid <= 1'b0;
            st          <= ST_WAIT;
          end
          if (fin) begin
            c_req_valid <= 1'b0;
            st          <= ST_RESP;
            s_bvalid    <= c_req_write;
            s_rvalid    <= !c_req_write;
            s_bresp     <= fin_resp;
            s_rresp     <= fin_resp;
            s_rdata     <= fin_data;
          end
        end
        default: begin
          if ((s_bvalid && s_bready) || (s_rvalid && s_rready)) begin
            s_bvalid <= 1'b0;
            s_rvalid <= 1'b0;
            st       <= ST_IDLE;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/cpl_err_mask_bridge_chk.sv
module cpl_err_mask_bridge_chk #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter logic [7:0] PRI_BUS = 8'd0,
  parameter logic [7:0] SEC_BUS = 8'd1
) (
  input logic          clk,
  input logic          rst,
  input logic          mask_en,
  input logic          s_awready,
  input logic          s_wready,
  input logic          s_arvalid,
  input logic          s_arready,
  input logic [AW-1:0] s_araddr,
  input logic          s_bvalid,
  input logic [1:0]    s_bresp,
  input logic          s_rvalid,
  input logic          s_rready,
  input logic [DW-1:0] s_rdata,
  input logic [1:0]    s_rresp,
  input logic          c_req_valid,
  input logic          c_req_ready,
  input logic [3:0]    err_flags,
  input logic [3:0]    err_clr
);
  logic [7:0] ar_bus;
  assign ar_bus = s_araddr[27:20];

  a_r9_ready_low: assert property (@(posedge clk) disable iff (rst)
    (s_bvalid || s_rvalid || c_req_valid) |-> !s_awready && !s_wready && !s_arready);

  a_r9_one_resp: assert property (@(posedge clk) disable iff (rst)
    !(s_bvalid && s_rvalid));

  a_r2_masked_read: assert property (@(posedge clk) disable iff (rst)
    ($rose(s_rvalid) && $past(mask_en)) |-> s_rresp == 2'b00);

  a_r2_masked_write: assert property (@(posedge clk) disable iff (rst)
    ($rose(s_bvalid) && $past(mask_en)) |-> s_bresp == 2'b00);

  a_r4_unknown_bus: assert property (@(posedge clk) disable iff (rst)
    (s_arvalid && s_arready && s_araddr[AW-1] && ar_bus != PRI_BUS && ar_bus != SEC_BUS)
      |=> s_rvalid && !c_req_valid && s_rresp == 2'b00 && s_rdata == {DW{1'b1}});

  a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
    (($past(err_flags) & ~$past(err_clr) & ~err_flags) == 4'b0000));

  a_r1_req_hold: assert property (@(posedge clk) disable iff (rst)
    (c_req_valid && !c_req_ready) |=> (c_req_valid || s_rvalid || s_bvalid));

  a_r2_rdata_stable: assert property (@(posedge clk) disable iff (rst)
    (s_rvalid && !s_rready) |=> s_rvalid && $stable(s_rdata) && $stable(s_rresp));
endmodule

bind cpl_err_mask_bridge cpl_err_mask_bridge_chk #(
  .AW(AW), .DW(DW), .PRI_BUS(PRI_BUS), .SEC_BUS(SEC_BUS)
) u_chk (
  .clk(clk), .rst(rst), .mask_en(mask_en), .s_awready(s_awready), .s_wready(s_wready),
  .s_arvalid(s_arvalid), .s_arready(s_arready), .s_araddr(s_araddr),
  .s_bvalid(s_bvalid), .s_bresp(s_bresp), .s_rvalid(s_rvalid), .s_rready(s_rready),
  .s_rdata(s_rdata), .s_rresp(s_rresp), .c_req_valid(c_req_valid),
  .c_req_ready(c_req_ready), .err_flags(err_flags), .err_clr(err_clr)
);

// File: tb/cpl_err_mask_bridge_test.sv
module cpl_err_mask_bridge_test;
  localparam int CLK_PERIOD = 10;
  localparam int TMO = 16;

  logic clk = 1'b0, rst = 1'b1, mask_en = 1'b1, link_up = 1'b1;
  logic s_awvalid = 0, s_wvalid = 0, s_arvalid = 0, s_bready = 1, s_rready = 1;
  logic [31:0] s_awaddr = 0, s_wdata = 0, s_araddr = 0;
  logic [3:0] s_wstrb = 4'hF;
  logic s_awready, s_wready, s_arready, s_bvalid, s_rvalid;
  logic [1:0] s_bresp, s_rresp;
  logic [31:0] s_rdata;
  logic c_req_valid, c_req_ready, c_req_write, c_req_cfg;
  logic [31:0] c_req_addr, c_req_wdata;
  logic [3:0] c_req_wstrb;
  logic c_cpl_valid = 0;
  logic [2:0] c_cpl_status = 0;
  logic [31:0] c_cpl_data = 0;
  logic [3:0] err_flags, err_clr = 0;
  logic [31:0] err_addr;

  int n_chk = 0, n_bad = 0;
  bit hang = 0, fire = 0;
  logic [2:0] cst = 3'b000;
  logic [31:0] cdat = 0;
  int nreq = 0;
  logic [31:0] l_addr, l_wdata;
  logic l_cfg, l_wr;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign c_req_ready = !hang;

  cpl_err_mask_bridge #(.TMO_CYC(TMO)) uut (.*);

  // Core model: completes one cycle after taking a request
  initial forever begin
    @(negedge clk);
    c_cpl_valid = 1'b0;
    if (fire) begin
      c_cpl_valid = 1'b1; c_cpl_status = cst; c_cpl_data = cdat; fire = 0;
    end else if (c_req_valid && c_req_ready) begin
      fire = 1; nreq++;
      l_addr = c_req_addr; l_wdata = c_req_wdata; l_cfg = c_req_cfg; l_wr = c_req_write;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] cfga(input int bus, input int dev, input int fn);
    return 32'h8000_0000 | (bus << 20) | (dev << 15) | (fn << 12) | 32'h10;
  endfunction

  task automatic rd(input logic [31:0] a, output logic [31:0] d, output logic [1:0] r, output int cyc);
    @(negedge clk); s_arvalid = 1; s_araddr = a;
    #1; while (!s_arready) begin @(negedge clk); #1; end
    @(posedge clk); cyc = 0;
    @(negedge clk); s_arvalid = 0;
    while (!s_rvalid && cyc < 1000) begin @(negedge clk); cyc++; end
    d = s_rdata; r = s_rresp;
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d, output logic [1:0] r, output int cyc);
    @(negedge clk); s_awvalid = 1; s_wvalid = 1; s_awaddr = a; s_wdata = d;
    #1; while (!s_awready) begin @(negedge clk); #1; end
    @(posedge clk); cyc = 0;
    @(negedge clk); s_awvalid = 0; s_wvalid = 0;
    while (!s_bvalid && cyc < 1000) begin @(negedge clk); cyc++; end
    r = s_bresp;
  endtask

  task automatic clear(input logic [3:0] m);
    @(negedge clk); err_clr = m;
    @(negedge clk); err_clr = 0;
  endtask

  task automatic t_reset();
    check("R11 bvalid", s_bvalid, 0);
    check("R11 rvalid", s_rvalid, 0);
    check("R11 req_valid", c_req_valid, 0);
    check("R11 flags", err_flags, 0);
  endtask

  task automatic t_forward();
    logic [31:0] d; logic [1:0] r; int c, n0;
    mask_en = 1; cst = 3'b000; cdat = 32'h1234_5678; n0 = nreq;
    rd(32'h0000_1000, d, r, c);
    check("R1 read data", d, 32'h1234_5678);
    check("R1 read resp", r, 2'b00);
    check("R1 forwarded once", nreq - n0, 1);
    check("R1 addr/cfg/wr", {l_addr, l_cfg, l_wr}, {32'h0000_1000, 1'b0, 1'b0});
    wr(32'h0000_2000, 32'hA5A5_0001, r, c);
    check("R1 write resp", r, 2'b00);
    check("R1 write fields", {l_wdata, l_wr}, {32'hA5A5_0001, 1'b1});
    rd(cfga(0, 0, 0), d, r, c);
    check("R1 own function forwarded as cfg", {l_cfg, l_addr}, {1'b1, cfga(0, 0, 0)});
    check("R10 success sets no flag", err_flags, 0);
  endtask

  task automatic t_masked();
    logic [31:0] d; logic [1:0] r; int c;
    mask_en = 1; cst = 3'b001;
    wr(32'h0000_3000, 32'h0, r, c);
    check("R2 masked UR write", r, 2'b00);
    check("R8 UR flag", err_flags, 4'b0001);
    check("R8 UR addr", err_addr, 32'h0000_3000);
    cst = 3'b100;
    rd(cfga(1, 0, 0), d, r, c);
    check("R2 masked CA cfg read data", d, 32'hFFFF_FFFF);
    check("R2 masked CA cfg read resp", r, 2'b00);
    check("R8 CA flag", err_flags, 4'b0011);
    check("R8 CA addr", err_addr, cfga(1, 0, 0));
    clear(4'b0001);
    check("R8 partial clear", err_flags, 4'b0010);
    clear(4'b1111);
    check("R8 full clear", err_flags, 4'b0000);
  endtask

  task automatic t_unmasked();
    logic [31:0] d; logic [1:0] r; int c;
    mask_en = 0; cst = 3'b001;
    rd(32'h0000_4000, d, r, c);
    check("R3 UR read slverr", r, 2'b10);
    cst = 3'b100;
    wr(32'h0000_5000, 32'h1, r, c);
    check("R3 CA write slverr", r, 2'b10);
    check("R10 unmasked no flags", err_flags, 0);
  endtask

  task automatic t_filter();
    logic [31:0] d; logic [1:0] r; int c, n0;
    mask_en = 0; n0 = nreq;
    rd(cfga(5, 0, 0), d, r, c);
    check("R4 unknown bus data", d, 32'hFFFF_FFFF);
    check("R4 unknown bus resp ignores mask", r, 2'b00);
    check("R6 filtered latency", c, 0);
    check("R8 filter flag", err_flags, 4'b1000);
    check("R8 filter addr", err_addr, cfga(5, 0, 0));
    wr(cfga(1, 3, 0), 32'h7, r, c);
    check("R4 secondary dev3 write resp", r, 2'b00);
    check("R6 filtered write latency", c, 0);
    rd(cfga(0, 0, 1), d, r, c);
    check("R4 own device fn1 data", d, 32'hFFFF_FFFF);
    check("R4 nothing forwarded", nreq - n0, 0);
    clear(4'b1000);
  endtask

  task automatic t_link();
    logic [31:0] d; logic [1:0] r; int c, n0;
    mask_en = 1; link_up = 0; cst = 3'b000; cdat = 32'h0BAD_F00D; n0 = nreq;
    rd(cfga(1, 0, 0), d, r, c);
    check("R5 link down secondary data", d, 32'hFFFF_FFFF);
    check("R5 link down secondary not forwarded", nreq - n0, 0);
    check("R5 link down flag", err_flags, 4'b1000);
    rd(cfga(0, 0, 0), d, r, c);
    check("R5 own function forwarded while down", {nreq - n0, d}, {32'd1, 32'h0BAD_F00D});
    link_up = 1;
    clear(4'b1111);
  endtask

  task automatic t_timeout();
    logic [31:0] d; logic [1:0] r; int c;
    mask_en = 1; hang = 1;
    fork
      rd(32'h0000_6000, d, r, c);
      begin
        repeat (5) @(negedge clk);
        s_awvalid = 1; s_wvalid = 1; #1;
        check("R9 no accept while busy", {s_awready, s_wready}, 2'b00);
        s_awvalid = 0; s_wvalid = 0;
      end
    join
    check("R7 timeout cycle", c, TMO);
    check("R7 masked timeout data", d, 32'hFFFF_FFFF);
    check("R7 masked timeout resp", r, 2'b00);
    check("R8 timeout flag", err_flags, 4'b0100);
    mask_en = 0;
    wr(32'h0000_7000, 32'h2, r, c);
    check("R7 unmasked timeout resp", r, 2'b10);
    check("R7 unmasked timeout cycle", c, TMO);
    check("R10 unmasked timeout no flag", err_flags, 4'b0100);
    hang = 0;
    clear(4'b1111);
  endtask

  task automatic t_accept_rules();
    @(negedge clk);
    s_awvalid = 1; s_wvalid = 0; #1;
    check("R9 address without data refused", s_awready, 0);
    s_wvalid = 1; s_arvalid = 1; #1;
    check("R9 write wins over read", {s_awready, s_wready, s_arready}, 3'b110);
    s_awvalid = 0; s_wvalid = 0; #1;
    check("R9 read alone accepted", s_arready, 1);
    s_arvalid = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    t_reset();
    t_forward();
    t_masked();
    t_unmasked();
    t_filter();
    t_link();
    t_timeout();
    t_accept_rules();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule